// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block sits on the receive side of a CAN controller. When a new frame's identifier bytes have been assembled, the controller presents them together with a one-cycle valid strobe. The block compares them against a set of programmable code and mask bytes. One clock later it reports whether any filter accepted the frame and which filter that was. When no filter matches, the accept output stays low and the controller drops the frame.

The eight code bytes and eight mask bytes form two banks of four. A mode register sets how the banks are used. In wide mode each bank is one filter over all four identifier bytes, which gives two filters. In narrow mode each byte pair is one filter over the first two identifier bytes, which gives four filters. A mask bit of 1 makes that identifier bit a don't care. Software reads the configuration through a byte-wide register port at any time. It can change the configuration only while the controller holds both its initialization request and its initialization acknowledge flags high.

Top module: `can_accept_filter`

## Requirements
- R1: After a synchronous reset, every code byte, every mask byte and the mode register read 0. Mode 0 is wide mode. `accept` is low and `hit_index` is 0.
- R2: Register map:
  - Addresses 0 to 7 hold code bytes 0 to 7.
  - Addresses 8 to 15 hold mask bytes 0 to 7.
  - Address 16 holds the mode in bits [1:0], and its upper bits read 0.
  - Every other address reads 0.
  - `reg_rdata` follows `reg_addr` combinationally, at any time.
- R3: A write takes effect only if `init_req` and `init_ack` are both 1 in the cycle of the write. Any other write leaves the registers and the filtering unchanged.
- R4: A mask bit of 1 makes the matching identifier bit a don't care. A mask bit of 0 requires that identifier bit to equal the code bit. A filter hits only when every bit it covers satisfies this. With the three low bits of the second mask byte of a filter set, the three low bits of identifier byte 1 are ignored, which is the setting used for standard identifiers.
- R5: Mode 0 (wide) has two filters. Filter 0 compares code and mask bytes 0 to 3 with identifier bytes 0 to 3. Filter 1 compares bytes 4 to 7 with identifier bytes 0 to 3. Identifier byte n is carried on `id_data[31-8n -: 8]`.
- R6: Mode 1 (narrow) has four filters. Filter k compares code and mask bytes 2k and 2k+1 with identifier bytes 0 and 1. Identifier bytes 2 and 3 have no effect in this mode.
- R7: In modes 2 and 3 no filter hits, and `accept` stays low.
- R8: `accept` is high for exactly the cycle after each cycle in which `id_valid` is high and at least one filter hits. Consecutive strobes give consecutive pulses. At all other times `accept` is low.
- R9: While `accept` is high, `hit_index` gives the lowest-numbered filter that hit. While `accept` is low, `hit_index` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Controller initialization request flag |
| init_ack | input | 1 | Controller initialization acknowledge flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| id_valid | input | 1 | Identifier bytes valid strobe |
| id_data | input | 32 | Received identifier bytes, byte 0 in the top bits |
| accept | output | 1 | Frame accepted pulse |
| hit_index | output | 2 | Lowest filter that hit |

## Verification
Two configurations are each walked through a table of identifiers.

- **Wide configuration.** It holds one exact extended-identifier filter and one standard-identifier filter with the low three bits of byte 1 masked. Its table includes:
  - identifiers that differ from a code only in the last bit, which separate exact matching from partial matching;
  - identifiers that vary only in the masked bits, which separate a don't-care bit from a compared bit.
- **Narrow configuration.** It has overlapping filters that several identifiers hit at once. These identifiers expose the priority order. Changing the trailing identifier bytes shows that those bytes are ignored in this mode.

Directed cases cover the following:
- the reset state and the all-zero match after reset;
- writes attempted with only one initialization flag set;
- the reserved modes;
- back-to-back strobes, which distinguish a level output from a true pulse.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_BYTES  = 8;
    localparam int BANK_BYTES = 4;
    localparam int ID_BYTES   = 4;
    localparam int PAIR_BYTES = 2;
    localparam int ID_W       = ID_BYTES * BYTE_W;
    localparam int NUM_WIDE   = NUM_BYTES / BANK_BYTES;
    localparam int NUM_FILT   = NUM_BYTES / PAIR_BYTES;
    localparam int IDX_W      = $clog2(NUM_FILT);
    localparam int SEL_W      = $clog2(NUM_BYTES);
    localparam int ADDR_W     = 5;
    localparam int MASK_BASE  = NUM_BYTES;
    localparam int MODE_ADDR  = 2 * NUM_BYTES;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t [NUM_BYTES-1:0] bank_t;

    typedef enum logic [1:0] {
        FM_WIDE   = 2'd0,
        FM_NARROW = 2'd1,
        FM_RSVD_A = 2'd2,
        FM_RSVD_B = 2'd3
    } fmode_e;

    typedef struct packed {
        bank_t  code;
        bank_t  mask;
        fmode_e mode;
    } fcfg_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } fres_t;

    // A bit passes when it equals the code bit or its mask bit is set.
    function automatic logic byte_ok(byte_t code, byte_t mask, byte_t rx);
        return &(~(code ^ rx) | mask);
    endfunction

    // Identifier byte n sits in the top-down order of the received word.
    function automatic byte_t id_byte(logic [ID_W-1:0] id, int n);
        return id[ID_W-1-BYTE_W*n -: BYTE_W];
    endfunction

    // Lowest set bit wins.
    function automatic fres_t pick_lowest(logic [NUM_FILT-1:0] h);
        fres_t r;
        r = '0;
        for (int i = NUM_FILT - 1; i >= 0; i--) begin
            if (h[i]) begin
                r.hit = 1'b1;
                r.idx = IDX_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
    import can_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init_req,
    input  logic              init_ack,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wdata,
    output byte_t             rdata,
    output fcfg_t             cfg
);

    logic             wr_ok;
    logic [SEL_W-1:0] sel;
    logic             in_code;
    logic             in_mask;
    logic             in_mode;

    assign wr_ok   = init_req & init_ack & wr_en;
    assign sel     = addr[SEL_W-1:0];
    assign in_code = addr < ADDR_W'(MASK_BASE);
    assign in_mask = !in_code && (addr < ADDR_W'(MODE_ADDR));
    assign in_mode = addr == ADDR_W'(MODE_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_ok) begin
            if (in_code) begin
                cfg.code[sel] <= wdata;
            end else if (in_mask) begin
                cfg.mask[sel] <= wdata;
            end else if (in_mode) begin
                cfg.mode <= fmode_e'(wdata[1:0]);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (in_code) begin
            rdata = cfg.code[sel];
        end else if (in_mask) begin
            rdata = cfg.mask[sel];
        end else if (in_mode) begin
            rdata = BYTE_W'(cfg.mode);
        end
    end

    // R3: without both init flags the configuration holds
    a_r3_locked_outside_init: assert property (@(posedge clk) disable iff (rst)
        !(init_req && init_ack) |=> $stable(cfg));

    // R2: a permitted mode write lands in the mode register
    a_r2_mode_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && init_req && init_ack && addr == ADDR_W'(MODE_ADDR))
            |=> (cfg.mode == $past(wdata[1:0])));

endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
    import can_filt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  fcfg_t           cfg,
    input  logic [ID_W-1:0] id_data,
    output fres_t           res
);

    logic [NUM_WIDE-1:0] wide_hit;
    logic [NUM_FILT-1:0] narrow_hit;
    logic [NUM_FILT-1:0] hits;

    // Wide filters: one bank of BANK_BYTES bytes against all identifier bytes.
    for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide
        always_comb begin
            wide_hit[g] = 1'b1;
            for (int b = 0; b < ID_BYTES; b++) begin
                if (!byte_ok(cfg.code[g*BANK_BYTES+b], cfg.mask[g*BANK_BYTES+b],
                             id_byte(id_data, b))) begin
                    wide_hit[g] = 1'b0;
                end
            end
        end
    end

    // Narrow filters: one byte pair against the leading identifier bytes.
    for (genvar g = 0; g < NUM_FILT; g++) begin : g_narrow
        always_comb begin
            narrow_hit[g] = 1'b1;
            for (int b = 0; b < PAIR_BYTES; b++) begin
                if (!byte_ok(cfg.code[g*PAIR_BYTES+b], cfg.mask[g*PAIR_BYTES+b],
                             id_byte(id_data, b))) begin
                    narrow_hit[g] = 1'b0;
                end
            end
        end
    end

    always_comb begin
        unique case (cfg.mode)
            FM_WIDE:   hits = {{(NUM_FILT-NUM_WIDE){1'b0}}, wide_hit};
            FM_NARROW: hits = narrow_hit;
            default:   hits = '0;
        endcase
        res = pick_lowest(hits);
    end

    // R7: reserved modes never report a hit
    a_r7_reserved_silent: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == FM_RSVD_A || cfg.mode == FM_RSVD_B) |-> !res.hit);

    // R5: wide mode only has filters 0 and 1
    a_r5_wide_index_range: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == FM_WIDE && res.hit) |-> (res.idx < IDX_W'(NUM_WIDE)));

    // R9: the reported filter is one that hit
    a_r9_index_hit: assert property (@(posedge clk) disable iff (rst)
        res.hit |-> hits[res.idx]);

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init_req,
    input  logic              init_ack,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              id_valid,
    input  logic [ID_W-1:0]   id_data,
    output logic              accept,
    output logic [IDX_W-1:0]  hit_index
);

    fcfg_t cfg;
    fres_t res;

    can_filt_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .init_req (init_req),
        .init_ack (init_ack),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cfg      (cfg)
    );

    can_filt_match u_match (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .id_data (id_data),
        .res     (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            accept    <= 1'b0;
            hit_index <= '0;
        end else begin
            accept    <= id_valid & res.hit;
            hit_index <= (id_valid & res.hit) ? res.idx : '0;
        end
    end

    // R8: every accept pulse follows a strobe
    a_r8_accept_after_strobe: assert property (@(posedge clk) disable iff (rst)
        accept |-> $past(id_valid));

    // R8: a cycle with no strobe yields no accept next cycle
    a_r8_idle_no_accept: assert property (@(posedge clk) disable iff (rst)
        !id_valid |=> !accept);

    // R9: index parks at zero when nothing is accepted
    a_r9_index_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !accept |-> (hit_index == '0));

endmodule

// File: tb/can_accept_filter_tb.sv
`timescale 1ns/1ps
module can_accept_filter_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        init_req, init_ack, reg_wr;
    logic [4:0]  reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        id_valid;
    logic [31:0] id_data;
    logic        accept;
    logic [1:0]  hit_index;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    can_accept_filter u_dut (
        .clk(clk), .rst(rst), .init_req(init_req), .init_ack(init_ack),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .id_valid(id_valid), .id_data(id_data),
        .accept(accept), .hit_index(hit_index)
    );

    // {identifier, expected accept, expected index}
    localparam logic [34:0] TAB_WIDE [6] = '{
        {32'h12345678, 1'b1, 2'd0},
        {32'h12345679, 1'b0, 2'd0},
        {32'hA0400000, 1'b1, 2'd1},
        {32'hA047FFEE, 1'b1, 2'd1},
        {32'hA0480000, 1'b0, 2'd0},
        {32'hA1400000, 1'b0, 2'd0}
    };
    localparam logic [34:0] TAB_NARROW [6] = '{
        {32'h55AA1234, 1'b1, 2'd0},
        {32'h55AAFFFF, 1'b1, 2'd0},
        {32'h55AB0000, 1'b1, 2'd1},
        {32'h3F05FFFF, 1'b1, 2'd2},
        {32'h3F080000, 1'b1, 2'd3},
        {32'h00000000, 1'b1, 2'd3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input logic [31:0] id, output logic acc, output logic [1:0] idx,
                        output logic acc_next);
        @(negedge clk);
        id_valid = 1'b1; id_data = id;
        @(negedge clk);
        id_valid = 1'b0;
        acc = accept; idx = hit_index;
        @(negedge clk);
        acc_next = accept;
    endtask

    task automatic set_init(input logic r, input logic a);
        @(negedge clk);
        init_req = r; init_ack = a;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       acc, acc_n;
        logic [1:0] idx;
        rst = 1'b1; init_req = 0; init_ack = 0; reg_wr = 0; reg_addr = '0;
        reg_wdata = '0; id_valid = 0; id_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 accept", 32'(accept), 32'd0);
        chk("R1 index", 32'(hit_index), 32'd0);
        for (int a = 0; a <= 16; a++) begin
            rd(5'(a), d);
            chk("R1 reg reset", 32'(d), 32'd0);
        end
        send(32'h00000000, acc, idx, acc_n);
        chk("R1 zero id accept", 32'({acc, idx}), 32'({1'b1, 2'd0}));
        send(32'h00000001, acc, idx, acc_n);
        chk("R1 nonzero id drop", 32'({acc, idx}), 32'd0);

        // R3: writes with one flag only are ignored
        set_init(1, 0);
        wr(5'd0, 8'hFF);
        rd(5'd0, d); chk("R3 req only", 32'(d), 32'd0);
        set_init(0, 1);
        wr(5'd9, 8'hFF);
        rd(5'd9, d); chk("R3 ack only", 32'(d), 32'd0);

        // R2: map readback and out-of-range address
        set_init(1, 1);
        wr(5'd16, 8'hFF);
        rd(5'd16, d); chk("R2 mode bits", 32'(d), 32'h03);
        wr(5'd20, 8'h5A);
        rd(5'd20, d); chk("R2 unmapped", 32'(d), 32'd0);

        // wide config: filter0 exact 12345678, filter1 standard id A0 / 0100_0xxx
        wr(5'd16, 8'h00);
        wr(5'd0, 8'h12); wr(5'd1, 8'h34); wr(5'd2, 8'h56); wr(5'd3, 8'h78);
        wr(5'd4, 8'hA0); wr(5'd5, 8'h40); wr(5'd6, 8'h00); wr(5'd7, 8'h00);
        wr(5'd13, 8'h07); wr(5'd14, 8'hFF); wr(5'd15, 8'hFF);
        rd(5'd13, d); chk("R2 mask readback", 32'(d), 32'h07);
        set_init(0, 0);

        // R3: locked write must not change the mode or the filtering
        wr(5'd16, 8'h01);
        rd(5'd16, d); chk("R3 mode locked", 32'(d), 32'd0);

        for (int i = 0; i < 6; i++) begin
            send(TAB_WIDE[i][34:3], acc, idx, acc_n);
            chk("R4/R5 wide accept", 32'(acc), 32'(TAB_WIDE[i][2]));
            chk("R9 wide index", 32'(idx), 32'(TAB_WIDE[i][1:0]));
            chk("R8 wide pulse ends", 32'(acc_n), 32'd0);
        end

        // narrow config
        set_init(1, 1);
        wr(5'd16, 8'h01);
        wr(5'd0, 8'h55); wr(5'd1, 8'hAA); wr(5'd8, 8'h00); wr(5'd9, 8'h00);
        wr(5'd2, 8'h55); wr(5'd3, 8'hA0); wr(5'd10, 8'h00); wr(5'd11, 8'h0F);
        wr(5'd4, 8'h30); wr(5'd5, 8'h00); wr(5'd12, 8'h0F); wr(5'd13, 8'h07);
        wr(5'd6, 8'h00); wr(5'd7, 8'h00); wr(5'd14, 8'hFF); wr(5'd15, 8'hFF);
        set_init(0, 0);
        for (int i = 0; i < 6; i++) begin
            send(TAB_NARROW[i][34:3], acc, idx, acc_n);
            chk("R6 narrow accept", 32'(acc), 32'(TAB_NARROW[i][2]));
            chk("R9 narrow index", 32'(idx), 32'(TAB_NARROW[i][1:0]));
        end

        // filter3 becomes exact 0000
        set_init(1, 1);
        wr(5'd14, 8'h00); wr(5'd15, 8'h00);
        set_init(0, 0);
        send(32'h77000000, acc, idx, acc_n);
        chk("R4 all miss", 32'({acc, idx}), 32'd0);

        // R8: back-to-back strobes give two pulses
        @(negedge clk);
        id_valid = 1'b1; id_data = 32'h55AA0000;
        @(negedge clk);
        id_data = 32'h00000000;
        chk("R8 first pulse", 32'({accept, hit_index}), 32'({1'b1, 2'd0}));
        @(negedge clk);
        id_valid = 1'b0;
        chk("R8 second pulse", 32'({accept, hit_index}), 32'({1'b1, 2'd3}));
        @(negedge clk);
        chk("R8 idle low", 32'(accept), 32'd0);

        // R7: reserved modes
        set_init(1, 1);
        wr(5'd16, 8'h02);
        set_init(0, 0);
        send(32'h00000000, acc, idx, acc_n);
        chk("R7 mode2", 32'({acc, idx}), 32'd0);
        set_init(1, 1);
        wr(5'd16, 8'h03);
        set_init(0, 0);
        send(32'h55AA0000, acc, idx, acc_n);
        chk("R7 mode3", 32'({acc, idx}), 32'd0);
        set_init(1, 1);
        wr(5'd16, 8'h01);
        set_init(0, 0);
        send(32'h00000000, acc, idx, acc_n);
        chk("R6 narrow restored", 32'({acc, idx}), 32'({1'b1, 2'd3}));

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule